// File: doc/BRIEF.md
# Address-Window Bus Interceptor

This block sits in series on an outbound TL-UL host connection and claims a small address window for traffic between software on an embedded processor and the testbench. Requests whose address lies outside the window pass unchanged to the outbound host-side port, and their responses come back unchanged on the inbound port. Requests inside the window never leave the block: a local sink answers them. The sink can hold the data in a small single-port word memory, or it can simply acknowledge writes and discard their data. A monitor port shows every request the sink accepts, so a testbench can watch software writes to chosen window addresses. Reads into the window complete with an error by default, which keeps software portable to platforms where only writes are observed.

The window starts at the `win_base` input, which can change at run time; the testbench drives it and holds it at zero out of reset. The window spans `Depth` words of `DW/8` bytes each. The channels use a reduced TL-UL signal set: opcode, size, source, address, mask and data on the request channel, and opcode, size, source, data and error on the response channel.

A three-state steering machine keeps responses in request order. In `ST_IDLE` nothing is pending and either path may accept. A forwarded request causes the transition IDLE→FWD. In `ST_FWD` only forwarded requests are accepted, up to `FwdMax` outstanding, and the transition FWD→IDLE happens when the last forwarded response is consumed. A window request causes the transition IDLE→SINK. In `ST_SINK` nothing is accepted, and the transition SINK→IDLE happens when the sink response is consumed.

Top module: `tlw_intercept`

## Requirements
- R1: A request is a window hit when win_base ≤ address < win_base + Depth×(DW/8). A request that misses the window appears unchanged on the outbound request channel, and its response is returned unchanged on the inbound response channel. With base 0 and the defaults, address 0x1C hits and 0x20 misses.
- R2: A window hit is never presented on the outbound request channel. out_a_valid is low in the cycle the sink accepts a request.
- R3: A new win_base value takes effect for the next requests. Addresses in the new window hit, and addresses in the old window are forwarded.
- R4: With storage on and read errors off, a Get (opcode 4) returns AccessAckData (opcode 1) with error low. It carries the stored word at index (address − win_base)/(DW/8) and echoes the request's source and size.
- R5: PutFullData (opcode 0) and PutPartialData (opcode 1) into the window receive AccessAck (opcode 0) with error low and echo the source and size. Only the bytes whose mask bit is set are written, where mask bit b covers data bits 8b+7..8b.
- R6: With read errors on (the default), a Get into the window returns AccessAckData with error high and data zero.
- R7: With storage off, window writes are acknowledged and discarded. With read errors also off, a window Get returns data zero with error low.
- R8: Responses reach the inbound port in request order. No request is accepted on one path while a response is still pending on the other path.
- R9: The sink holds at most one request. Its response is valid in the cycle after acceptance and stays stable until in_d_ready is high.
- R10: mon_valid is high exactly in cycles where the sink accepts a request. In those cycles mon_address, mon_opcode, mon_mask and mon_data equal the accepted request.
- R11: Reset clears pending responses and the steering state, so the block returns to ST_IDLE. It leaves the stored words intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | AW | Byte address of the first window word |
| in_a_valid | input | 1 | Inbound request valid |
| in_a_ready | output | 1 | Inbound request accepted |
| in_a_opcode | input | 3 | Request opcode |
| in_a_size | input | SzW | Request size (log2 bytes) |
| in_a_source | input | SrcW | Request source ID |
| in_a_address | input | AW | Request byte address |
| in_a_mask | input | DW/8 | Request byte mask |
| in_a_data | input | DW | Request write data |
| in_d_valid | output | 1 | Inbound response valid |
| in_d_ready | input | 1 | Host ready for response |
| in_d_opcode | output | 3 | Response opcode |
| in_d_size | output | SzW | Response size |
| in_d_source | output | SrcW | Response source ID |
| in_d_data | output | DW | Response read data |
| in_d_error | output | 1 | Response error |
| out_a_valid | output | 1 | Forwarded request valid |
| out_a_ready | input | 1 | Downstream accepts request |
| out_a_opcode | output | 3 | Forwarded opcode |
| out_a_size | output | SzW | Forwarded size |
| out_a_source | output | SrcW | Forwarded source ID |
| out_a_address | output | AW | Forwarded address |
| out_a_mask | output | DW/8 | Forwarded mask |
| out_a_data | output | DW | Forwarded data |
| out_d_valid | input | 1 | Downstream response valid |
| out_d_ready | output | 1 | Block ready for downstream response |
| out_d_opcode | input | 3 | Downstream response opcode |
| out_d_size | input | SzW | Downstream response size |
| out_d_source | input | SrcW | Downstream response source ID |
| out_d_data | input | DW | Downstream response data |
| out_d_error | input | 1 | Downstream response error |
| mon_valid | output | 1 | Sink accepted a request this cycle |
| mon_opcode | output | 3 | Accepted request opcode |
| mon_address | output | AW | Accepted request address |
| mon_mask | output | DW/8 | Accepted request mask |
| mon_data | output | DW | Accepted request data |

## Verification
Two functions can meet in the same cycle. A forwarded response is still being returned while a window request waits at the inbound port, and both would claim the response channel if the steering machine let the window request through. The bench provokes this by issuing forwarded Gets and window requests back to back, while a downstream model answers a cycle or more late and the host toggles in_d_ready. The scoreboard then judges every response against its own queue of expected items in issue order, so an overtaking response or a merged pair shows up as a mismatch in opcode, source or data.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    // request channel opcodes
    localparam logic [2:0] OP_PUT_FULL = 3'd0;
    localparam logic [2:0] OP_PUT_PART = 3'd1;
    localparam logic [2:0] OP_GET      = 3'd4;

    // response channel opcodes
    localparam logic [2:0] RSP_ACK      = 3'd0;
    localparam logic [2:0] RSP_ACK_DATA = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_SINK = 2'd2
    } steer_state_e;

endpackage

// File: rtl/tlw_window_decode.sv
module tlw_window_decode #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int Depth = 8,
    parameter int IdxW  = (Depth > 1) ? $clog2(Depth) : 1
) (
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   base,
    output logic            hit,
    output logic [IdxW-1:0] idx
);

    localparam int BYTES = DW / 8;
    localparam int SPAN  = Depth * BYTES;
    localparam int OFFW  = (BYTES > 1) ? $clog2(BYTES) : 0;

    logic [AW:0]   diff;
    logic [AW-1:0] offset;

    always_comb begin
        diff   = {1'b0, addr} - {1'b0, base};
        offset = diff[AW-1:0];
        hit    = !diff[AW] && (offset < AW'(SPAN));
        idx    = IdxW'(offset >> OFFW);
    end

endmodule

// File: rtl/tlw_steer.sv
module tlw_steer
    import tlw_pkg::*;
#(
    parameter int FwdMax = 4,
    parameter int CntW   = $clog2(FwdMax + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_hit,
    input  logic fwd_ready,
    input  logic sink_ready,
    input  logic fwd_rsp_fire,
    input  logic sink_rsp_fire,
    output logic fwd_valid,
    output logic sink_valid,
    output logic req_ready
);

    steer_state_e state_q, state_d;
    logic [CntW-1:0] cnt_q, cnt_d;
    logic fwd_open, sink_open;
    logic fwd_acc, sink_acc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs per state
    always_comb begin
        fwd_open  = 1'b0;
        sink_open = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fwd_open  = 1'b1;
                sink_open = 1'b1;
            end
            ST_FWD:  fwd_open = (cnt_q < CntW'(FwdMax));
            ST_SINK: ;
            default: ;
        endcase
        fwd_valid  = req_valid && !req_hit && fwd_open;
        sink_valid = req_valid &&  req_hit && sink_open;
        req_ready  = req_hit ? (sink_open && sink_ready) : (fwd_open && fwd_ready);
    end

    // next state
    always_comb begin
        fwd_acc  = fwd_valid && fwd_ready;
        sink_acc = sink_valid && sink_ready;
        cnt_d    = cnt_q + CntW'(fwd_acc) - CntW'(fwd_rsp_fire);
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sink_acc)     state_d = ST_SINK;
                else if (fwd_acc) state_d = ST_FWD;
            end
            ST_FWD:  if (cnt_d == '0) state_d = ST_IDLE;
            ST_SINK: if (sink_rsp_fire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/tlw_store.sv
module tlw_store #(
    parameter int DW    = 32,
    parameter int Depth = 8,
    parameter int IdxW  = (Depth > 1) ? $clog2(Depth) : 1
) (
    input  logic            clk,
    input  logic            en,
    input  logic            we,
    input  logic [IdxW-1:0] idx,
    input  logic [DW/8-1:0] wmask,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);

    localparam int BYTES = DW / 8;

    logic [DW-1:0] mem [Depth];

    // single port: one write or one read per cycle, contents not reset
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (wmask[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end else begin
                rdata <= mem[idx];
            end
        end
    end

endmodule

// File: rtl/tlw_sink.sv
module tlw_sink
    import tlw_pkg::*;
#(
    parameter int DW        = 32,
    parameter int SrcW      = 8,
    parameter int SzW       = 2,
    parameter int Depth     = 8,
    parameter bit UseStore  = 1'b0,
    parameter bit ErrOnRead = 1'b1,
    parameter int IdxW      = (Depth > 1) ? $clog2(Depth) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_opcode,
    input  logic [SzW-1:0]  req_size,
    input  logic [SrcW-1:0] req_source,
    input  logic [IdxW-1:0] req_idx,
    input  logic [DW/8-1:0] req_mask,
    input  logic [DW-1:0]   req_data,
    output logic            d_valid,
    input  logic            d_ready,
    output logic [2:0]      d_opcode,
    output logic [SzW-1:0]  d_size,
    output logic [SrcW-1:0] d_source,
    output logic [DW-1:0]   d_data,
    output logic            d_error
);

    logic            pend_q;
    logic [2:0]      op_q;
    logic [SzW-1:0]  size_q;
    logic [SrcW-1:0] src_q;
    logic            err_q;
    logic            rd_q;
    logic            acc, is_get, is_put;
    logic [DW-1:0]   rdata;

    always_comb begin
        req_ready = !pend_q;
        acc       = req_valid && !pend_q;
        is_get    = (req_opcode == OP_GET);
        is_put    = (req_opcode == OP_PUT_FULL) || (req_opcode == OP_PUT_PART);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            op_q   <= RSP_ACK;
            size_q <= '0;
            src_q  <= '0;
            err_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else if (acc) begin
            pend_q <= 1'b1;
            op_q   <= is_get ? RSP_ACK_DATA : RSP_ACK;
            size_q <= req_size;
            src_q  <= req_source;
            err_q  <= is_get ? ErrOnRead : !is_put;
            rd_q   <= is_get && !ErrOnRead;
        end else if (pend_q && d_ready) begin
            pend_q <= 1'b0;
        end
    end

    generate
        if (UseStore) begin : g_store
            tlw_store #(.DW(DW), .Depth(Depth), .IdxW(IdxW)) u_store (
                .clk   (clk),
                .en    (acc && (is_get || is_put)),
                .we    (is_put),
                .idx   (req_idx),
                .wmask (req_mask),
                .wdata (req_data),
                .rdata (rdata)
            );
        end else begin : g_nostore
            assign rdata = '0;
        end
    endgenerate

    always_comb begin
        d_valid  = pend_q;
        d_opcode = op_q;
        d_size   = size_q;
        d_source = src_q;
        d_error  = err_q;
        d_data   = rd_q ? rdata : '0;
    end

endmodule

// File: rtl/tlw_intercept.sv
module tlw_intercept
    import tlw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int SrcW      = 8,
    parameter int SzW       = 2,
    parameter int Depth     = 8,
    parameter int FwdMax    = 4,
    parameter bit UseStore  = 1'b0,
    parameter bit ErrOnRead = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   win_base,
    input  logic            in_a_valid,
    output logic            in_a_ready,
    input  logic [2:0]      in_a_opcode,
    input  logic [SzW-1:0]  in_a_size,
    input  logic [SrcW-1:0] in_a_source,
    input  logic [AW-1:0]   in_a_address,
    input  logic [DW/8-1:0] in_a_mask,
    input  logic [DW-1:0]   in_a_data,
    output logic            in_d_valid,
    input  logic            in_d_ready,
    output logic [2:0]      in_d_opcode,
    output logic [SzW-1:0]  in_d_size,
    output logic [SrcW-1:0] in_d_source,
    output logic [DW-1:0]   in_d_data,
    output logic            in_d_error,
    output logic            out_a_valid,
    input  logic            out_a_ready,
    output logic [2:0]      out_a_opcode,
    output logic [SzW-1:0]  out_a_size,
    output logic [SrcW-1:0] out_a_source,
    output logic [AW-1:0]   out_a_address,
    output logic [DW/8-1:0] out_a_mask,
    output logic [DW-1:0]   out_a_data,
    input  logic            out_d_valid,
    output logic            out_d_ready,
    input  logic [2:0]      out_d_opcode,
    input  logic [SzW-1:0]  out_d_size,
    input  logic [SrcW-1:0] out_d_source,
    input  logic [DW-1:0]   out_d_data,
    input  logic            out_d_error,
    output logic            mon_valid,
    output logic [2:0]      mon_opcode,
    output logic [AW-1:0]   mon_address,
    output logic [DW/8-1:0] mon_mask,
    output logic [DW-1:0]   mon_data
);

    localparam int IdxW = (Depth > 1) ? $clog2(Depth) : 1;

    logic            hit;
    logic [IdxW-1:0] idx;
    logic            snk_a_valid, snk_a_ready;
    logic            snk_d_valid;
    logic [2:0]      snk_d_opcode;
    logic [SzW-1:0]  snk_d_size;
    logic [SrcW-1:0] snk_d_source;
    logic [DW-1:0]   snk_d_data;
    logic            snk_d_error;

    tlw_window_decode #(.AW(AW), .DW(DW), .Depth(Depth), .IdxW(IdxW)) u_decode (
        .addr (in_a_address),
        .base (win_base),
        .hit  (hit),
        .idx  (idx)
    );

    tlw_steer #(.FwdMax(FwdMax)) u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (in_a_valid),
        .req_hit       (hit),
        .fwd_ready     (out_a_ready),
        .sink_ready    (snk_a_ready),
        .fwd_rsp_fire  (out_d_valid && out_d_ready),
        .sink_rsp_fire (snk_d_valid && in_d_ready),
        .fwd_valid     (out_a_valid),
        .sink_valid    (snk_a_valid),
        .req_ready     (in_a_ready)
    );

    tlw_sink #(
        .DW(DW), .SrcW(SrcW), .SzW(SzW), .Depth(Depth),
        .UseStore(UseStore), .ErrOnRead(ErrOnRead), .IdxW(IdxW)
    ) u_sink (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (snk_a_valid),
        .req_ready  (snk_a_ready),
        .req_opcode (in_a_opcode),
        .req_size   (in_a_size),
        .req_source (in_a_source),
        .req_idx    (idx),
        .req_mask   (in_a_mask),
        .req_data   (in_a_data),
        .d_valid    (snk_d_valid),
        .d_ready    (in_d_ready),
        .d_opcode   (snk_d_opcode),
        .d_size     (snk_d_size),
        .d_source   (snk_d_source),
        .d_data     (snk_d_data),
        .d_error    (snk_d_error)
    );

    // forwarded request fields pass straight through
    always_comb begin
        out_a_opcode  = in_a_opcode;
        out_a_size    = in_a_size;
        out_a_source  = in_a_source;
        out_a_address = in_a_address;
        out_a_mask    = in_a_mask;
        out_a_data    = in_a_data;
    end

    // response merge: the steering machine keeps the two sources exclusive
    always_comb begin
        in_d_valid  = snk_d_valid || out_d_valid;
        out_d_ready = in_d_ready && !snk_d_valid;
        if (snk_d_valid) begin
            in_d_opcode = snk_d_opcode;
            in_d_size   = snk_d_size;
            in_d_source = snk_d_source;
            in_d_data   = snk_d_data;
            in_d_error  = snk_d_error;
        end else begin
            in_d_opcode = out_d_opcode;
            in_d_size   = out_d_size;
            in_d_source = out_d_source;
            in_d_data   = out_d_data;
            in_d_error  = out_d_error;
        end
    end

    // monitor shows each sink acceptance
    always_comb begin
        mon_valid   = snk_a_valid && snk_a_ready;
        mon_opcode  = in_a_opcode;
        mon_address = in_a_address;
        mon_mask    = in_a_mask;
        mon_data    = in_a_data;
    end

endmodule

// File: rtl/tlw_intercept_chk.sv
module tlw_intercept_chk #(
    parameter int DW   = 32,
    parameter int SrcW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_a_valid,
    input logic            in_a_ready,
    input logic            out_a_valid,
    input logic            mon_valid,
    input logic            in_d_valid,
    input logic            in_d_ready,
    input logic            sink_d_valid,
    input logic [2:0]      in_d_opcode,
    input logic [SrcW-1:0] in_d_source,
    input logic [DW-1:0]   in_d_data
);

    // R2
    sink_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_valid |-> !out_a_valid);

    // R9
    sink_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_valid |=> in_d_valid);

    // R9
    sink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_d_valid && !in_d_ready) |=>
            (sink_d_valid && $stable(in_d_source) && $stable(in_d_data) && $stable(in_d_opcode)));

    // R8
    order_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sink_d_valid |-> !out_a_valid);

    // R10
    mon_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_valid |-> (in_a_valid && in_a_ready));

endmodule

bind tlw_intercept tlw_intercept_chk #(.DW(DW), .SrcW(SrcW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_a_valid   (in_a_valid),
    .in_a_ready   (in_a_ready),
    .out_a_valid  (out_a_valid),
    .mon_valid    (mon_valid),
    .in_d_valid   (in_d_valid),
    .in_d_ready   (in_d_ready),
    .sink_d_valid (snk_d_valid),
    .in_d_opcode  (in_d_opcode),
    .in_d_source  (in_d_source),
    .in_d_data    (in_d_data)
);

// File: tb/tlw_intercept_bench.sv
module tlw_intercept_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;
    localparam logic [31:0] DN_KEY = 32'h5A5A_0F0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // main instance: storage on, read errors off
    logic [31:0] win_base = '0;
    logic        in_a_valid = 0, in_a_ready;
    logic [2:0]  in_a_opcode = 0;
    logic [1:0]  in_a_size = 2;
    logic [7:0]  in_a_source = 0;
    logic [31:0] in_a_address = 0;
    logic [3:0]  in_a_mask = 0;
    logic [31:0] in_a_data = 0;
    logic        in_d_valid, in_d_ready = 1, in_d_error;
    logic [2:0]  in_d_opcode;
    logic [1:0]  in_d_size;
    logic [7:0]  in_d_source;
    logic [31:0] in_d_data;
    logic        out_a_valid, out_a_ready = 1;
    logic [2:0]  out_a_opcode;
    logic [1:0]  out_a_size;
    logic [7:0]  out_a_source;
    logic [31:0] out_a_address;
    logic [3:0]  out_a_mask;
    logic [31:0] out_a_data;
    logic        out_d_valid = 0, out_d_ready, out_d_error = 0;
    logic [2:0]  out_d_opcode = 0;
    logic [1:0]  out_d_size = 0;
    logic [7:0]  out_d_source = 0;
    logic [31:0] out_d_data = 0;
    logic        mon_valid;
    logic [2:0]  mon_opcode;
    logic [31:0] mon_address;
    logic [3:0]  mon_mask;
    logic [31:0] mon_data;

    tlw_intercept #(.UseStore(1'b1), .ErrOnRead(1'b0)) u_tlw_intercept (
        .clk(clk), .rst_n(rst_n), .win_base(win_base),
        .in_a_valid(in_a_valid), .in_a_ready(in_a_ready), .in_a_opcode(in_a_opcode),
        .in_a_size(in_a_size), .in_a_source(in_a_source), .in_a_address(in_a_address),
        .in_a_mask(in_a_mask), .in_a_data(in_a_data),
        .in_d_valid(in_d_valid), .in_d_ready(in_d_ready), .in_d_opcode(in_d_opcode),
        .in_d_size(in_d_size), .in_d_source(in_d_source), .in_d_data(in_d_data),
        .in_d_error(in_d_error),
        .out_a_valid(out_a_valid), .out_a_ready(out_a_ready), .out_a_opcode(out_a_opcode),
        .out_a_size(out_a_size), .out_a_source(out_a_source), .out_a_address(out_a_address),
        .out_a_mask(out_a_mask), .out_a_data(out_a_data),
        .out_d_valid(out_d_valid), .out_d_ready(out_d_ready), .out_d_opcode(out_d_opcode),
        .out_d_size(out_d_size), .out_d_source(out_d_source), .out_d_data(out_d_data),
        .out_d_error(out_d_error),
        .mon_valid(mon_valid), .mon_opcode(mon_opcode), .mon_address(mon_address),
        .mon_mask(mon_mask), .mon_data(mon_data)
    );

    // two storage-less instances sharing one stimulus
    logic [31:0] e_base = 32'h2000_0000;
    logic        e_a_valid = 0;
    logic [2:0]  e_a_opcode = 0;
    logic [1:0]  e_a_size = 2;
    logic [7:0]  e_a_source = 0;
    logic [31:0] e_a_address = 0;
    logic [3:0]  e_a_mask = 0;
    logic [31:0] e_a_data = 0;
    logic        e1_a_ready, e1_d_valid, e1_d_error, e1_oa_valid, e1_od_ready, e1_mon_valid;
    logic [2:0]  e1_d_opcode, e1_oa_opcode, e1_mon_opcode;
    logic [1:0]  e1_d_size, e1_oa_size;
    logic [7:0]  e1_d_source, e1_oa_source;
    logic [31:0] e1_d_data, e1_oa_address, e1_oa_data, e1_mon_address, e1_mon_data;
    logic [3:0]  e1_oa_mask, e1_mon_mask;
    logic        e2_a_ready, e2_d_valid, e2_d_error, e2_oa_valid, e2_od_ready, e2_mon_valid;
    logic [2:0]  e2_d_opcode, e2_oa_opcode, e2_mon_opcode;
    logic [1:0]  e2_d_size, e2_oa_size;
    logic [7:0]  e2_d_source, e2_oa_source;
    logic [31:0] e2_d_data, e2_oa_address, e2_oa_data, e2_mon_address, e2_mon_data;
    logic [3:0]  e2_oa_mask, e2_mon_mask;

    tlw_intercept u_tlw_intercept_err (
        .clk(clk), .rst_n(rst_n), .win_base(e_base),
        .in_a_valid(e_a_valid), .in_a_ready(e1_a_ready), .in_a_opcode(e_a_opcode),
        .in_a_size(e_a_size), .in_a_source(e_a_source), .in_a_address(e_a_address),
        .in_a_mask(e_a_mask), .in_a_data(e_a_data),
        .in_d_valid(e1_d_valid), .in_d_ready(1'b1), .in_d_opcode(e1_d_opcode),
        .in_d_size(e1_d_size), .in_d_source(e1_d_source), .in_d_data(e1_d_data),
        .in_d_error(e1_d_error),
        .out_a_valid(e1_oa_valid), .out_a_ready(1'b1), .out_a_opcode(e1_oa_opcode),
        .out_a_size(e1_oa_size), .out_a_source(e1_oa_source), .out_a_address(e1_oa_address),
        .out_a_mask(e1_oa_mask), .out_a_data(e1_oa_data),
        .out_d_valid(1'b0), .out_d_ready(e1_od_ready), .out_d_opcode(3'd0),
        .out_d_size(2'd0), .out_d_source(8'd0), .out_d_data(32'd0), .out_d_error(1'b0),
        .mon_valid(e1_mon_valid), .mon_opcode(e1_mon_opcode), .mon_address(e1_mon_address),
        .mon_mask(e1_mon_mask), .mon_data(e1_mon_data)
    );

    tlw_intercept #(.UseStore(1'b0), .ErrOnRead(1'b0)) u_tlw_intercept_nostore (
        .clk(clk), .rst_n(rst_n), .win_base(e_base),
        .in_a_valid(e_a_valid), .in_a_ready(e2_a_ready), .in_a_opcode(e_a_opcode),
        .in_a_size(e_a_size), .in_a_source(e_a_source), .in_a_address(e_a_address),
        .in_a_mask(e_a_mask), .in_a_data(e_a_data),
        .in_d_valid(e2_d_valid), .in_d_ready(1'b1), .in_d_opcode(e2_d_opcode),
        .in_d_size(e2_d_size), .in_d_source(e2_d_source), .in_d_data(e2_d_data),
        .in_d_error(e2_d_error),
        .out_a_valid(e2_oa_valid), .out_a_ready(1'b1), .out_a_opcode(e2_oa_opcode),
        .out_a_size(e2_oa_size), .out_a_source(e2_oa_source), .out_a_address(e2_oa_address),
        .out_a_mask(e2_oa_mask), .out_a_data(e2_oa_data),
        .out_d_valid(1'b0), .out_d_ready(e2_od_ready), .out_d_opcode(3'd0),
        .out_d_size(2'd0), .out_d_source(8'd0), .out_d_data(32'd0), .out_d_error(1'b0),
        .mon_valid(e2_mon_valid), .mon_opcode(e2_mon_opcode), .mon_address(e2_mon_address),
        .mon_mask(e2_mon_mask), .mon_data(e2_mon_data)
    );

    // scoreboard items
    typedef struct {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [7:0]  src;
        logic [31:0] data;
        logic        err;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    // downstream model queue
    typedef struct {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [7:0]  src;
        logic [31:0] addr;
    } dn_t;
    dn_t dn_q[$];
    bit  dn_taken = 0;
    bit  dr_mode = 0;
    bit  cur_hit = 0;
    bit  lat_pend = 0;
    logic [31:0] mdl [8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] d;
        d = {1'b0, a} - {1'b0, b};
        return !d[32] && (d[31:0] < 32'd32);
    endfunction

    // monitor, downstream responder and host ready
    initial begin
        forever begin
            @(negedge clk);
            if (dn_taken) begin
                dn_q.delete(0);
                out_d_valid = 0;
                dn_taken = 0;
            end else if (!out_d_valid && dn_q.size() > 0 && rst_n) begin
                out_d_valid  = 1;
                out_d_opcode = (dn_q[0].op == 3'd4) ? 3'd1 : 3'd0;
                out_d_size   = dn_q[0].sz;
                out_d_source = dn_q[0].src;
                out_d_data   = (dn_q[0].op == 3'd4) ? (dn_q[0].addr ^ DN_KEY) : 32'd0;
            end
            in_d_ready = dr_mode ? !in_d_ready : 1'b1;
            #(Q);
            if (rst_n) begin
                dn_taken = out_d_valid && out_d_ready;
                if (out_a_valid && out_a_ready)
                    dn_q.push_back('{op: out_a_opcode, sz: out_a_size, src: out_a_source, addr: out_a_address});
                if (lat_pend) begin
                    // R9: sink response valid one cycle after acceptance
                    chk(in_d_valid, "R9 latency", {31'd0, in_d_valid}, 32'd1);
                    lat_pend = 0;
                end
                if (in_a_valid && in_a_ready) begin
                    // R10: monitor flags exactly the sink acceptances
                    chk(mon_valid == cur_hit, "R10 mon_valid", {31'd0, mon_valid}, {31'd0, cur_hit});
                    if (cur_hit) begin
                        chk(!out_a_valid, "R2 no forward", {31'd0, out_a_valid}, 32'd0);
                        chk(mon_address == in_a_address, "R10 mon_address", mon_address, in_a_address);
                        lat_pend = 1;
                    end
                end
                if (in_d_valid && in_d_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected response", {29'd0, in_d_opcode}, 32'd0);
                    end else begin
                        exp_t  e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(in_d_opcode == e.op, {t, " opcode"}, {29'd0, in_d_opcode}, {29'd0, e.op});
                        chk(in_d_source == e.src, {t, " source"}, {24'd0, in_d_source}, {24'd0, e.src});
                        chk(in_d_size == e.sz, {t, " size"}, {30'd0, in_d_size}, {30'd0, e.sz});
                        chk(in_d_data == e.data, {t, " data"}, in_d_data, e.data);
                        chk(in_d_error == e.err, {t, " error"}, {31'd0, in_d_error}, {31'd0, e.err});
                    end
                end
            end
        end
    end

    // driver: called at a negedge, returns at a negedge with valid low
    task automatic send(input logic [2:0] op, input logic [31:0] addr, input logic [3:0] mask,
                        input logic [31:0] data, input logic [7:0] src, input string tag);
        exp_t e;
        bit   h;
        int   ix;
        h = in_win(addr, win_base);
        e.op = (op == 3'd4) ? 3'd1 : 3'd0;
        e.sz = 2'd2;
        e.src = src;
        e.err = 1'b0;
        e.data = 32'd0;
        if (h) begin
            ix = int'((addr - win_base) >> 2);
            if (op == 3'd4) e.data = mdl[ix];
            else begin
                for (int b = 0; b < 4; b++)
                    if (mask[b]) mdl[ix][b*8 +: 8] = data[b*8 +: 8];
            end
        end else if (op == 3'd4) begin
            e.data = addr ^ DN_KEY;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cur_hit      = h;
        in_a_opcode  = op;
        in_a_size    = 2'd2;
        in_a_source  = src;
        in_a_address = addr;
        in_a_mask    = mask;
        in_a_data    = data;
        in_a_valid   = 1;
        #(Q);
        while (!in_a_ready) begin
            @(negedge clk);
            #(Q);
        end
        @(negedge clk);
        in_a_valid = 0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, "R8 drain", exp_q.size(), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        #1;
        exp_q.delete();
        tag_q.delete();
        dn_q.delete();
        out_d_valid = 0;
        dn_taken = 0;
        lat_pend = 0;
        repeat (2) @(negedge clk);
        #(Q);
        // R11: no pending response, nothing forwarded during reset
        chk(!in_d_valid, "R11 reset d_valid", {31'd0, in_d_valid}, 32'd0);
        chk(!out_a_valid, "R11 reset out_a_valid", {31'd0, out_a_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // drives the storage-less pair and checks one response each
    task automatic esend(input logic [2:0] op, input logic [31:0] addr, input logic [7:0] src,
                         input logic [2:0] x_op, input logic x_err1, input string tag);
        e_a_opcode  = op;
        e_a_address = addr;
        e_a_source  = src;
        e_a_mask    = 4'hF;
        e_a_data    = 32'hDEAD_BEEF;
        e_a_valid   = 1;
        #(Q);
        while (!e1_a_ready) begin
            @(negedge clk);
            #(Q);
        end
        @(negedge clk);
        e_a_valid = 0;
        #(Q);
        chk(e1_d_valid && e2_d_valid, {tag, " R9 valid"}, {30'd0, e1_d_valid, e2_d_valid}, 32'd3);
        chk(e1_d_opcode == x_op, {tag, " opcode"}, {29'd0, e1_d_opcode}, {29'd0, x_op});
        chk(e2_d_opcode == x_op, {tag, " opcode"}, {29'd0, e2_d_opcode}, {29'd0, x_op});
        chk(e1_d_source == src && e2_d_source == src, {tag, " source"}, {24'd0, e1_d_source}, {24'd0, src});
        chk(e1_d_error == x_err1, {tag, " error"}, {31'd0, e1_d_error}, {31'd0, x_err1});
        chk(e2_d_error == 1'b0, "R7 error", {31'd0, e2_d_error}, 32'd0);
        chk(e1_d_data == 32'd0, "R6 data", e1_d_data, 32'd0);
        chk(e2_d_data == 32'd0, "R7 discarded data", e2_d_data, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #(Q);
        // R11: reset state
        chk(!in_d_valid, "R11 reset d_valid", {31'd0, in_d_valid}, 32'd0);
        chk(!out_a_valid, "R11 reset out_a_valid", {31'd0, out_a_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R5, R4, R1: window at base 0
        send(3'd0, 32'h0000_0000, 4'hF, 32'h1111_2222, 8'h01, "R5 put");
        send(3'd0, 32'h0000_001C, 4'hF, 32'h7777_8888, 8'h02, "R1 top word");
        send(3'd4, 32'h0000_0000, 4'hF, 32'd0, 8'h03, "R4 get");
        send(3'd4, 32'h0000_001C, 4'hF, 32'd0, 8'h04, "R4 get top");
        send(3'd4, 32'h0000_0020, 4'hF, 32'd0, 8'h05, "R1 past end");
        send(3'd0, 32'h0000_0040, 4'hF, 32'h5555_0000, 8'h06, "R1 forward put");
        drain();

        // R5: partial write under mask
        send(3'd1, 32'h0000_0000, 4'b0101, 32'hAABB_CCDD, 8'h07, "R5 partial");
        send(3'd4, 32'h0000_0000, 4'hF, 32'd0, 8'h08, "R5 masked read");
        send(3'd0, 32'h0000_0004, 4'hF, 32'h0404_0404, 8'h09, "R5 put");
        drain();

        // R8: mixed paths back to back
        send(3'd4, 32'h0000_0100, 4'hF, 32'd0, 8'h10, "R8 fwd");
        send(3'd4, 32'h0000_0004, 4'hF, 32'd0, 8'h11, "R8 sink");
        send(3'd4, 32'h0000_0104, 4'hF, 32'd0, 8'h12, "R8 fwd");
        send(3'd4, 32'h0000_0108, 4'hF, 32'd0, 8'h13, "R8 fwd");
        send(3'd4, 32'h0000_010C, 4'hF, 32'd0, 8'h14, "R8 fwd");
        send(3'd0, 32'h0000_0008, 4'hF, 32'h0808_0808, 8'h15, "R8 sink put");
        send(3'd4, 32'h0000_0110, 4'hF, 32'd0, 8'h16, "R8 fwd");
        drain();

        // R9: host back-pressure
        dr_mode = 1;
        send(3'd4, 32'h0000_0008, 4'hF, 32'd0, 8'h20, "R9 get");
        send(3'd4, 32'h0000_0200, 4'hF, 32'd0, 8'h21, "R9 fwd");
        send(3'd4, 32'h0000_001C, 4'hF, 32'd0, 8'h22, "R9 get");
        drain();
        dr_mode = 0;
        @(negedge clk);

        // R3: move the window
        win_base = 32'h3000_0000;
        send(3'd4, 32'h0000_0000, 4'hF, 32'd0, 8'h30, "R3 old window");
        send(3'd0, 32'h3000_001C, 4'hF, 32'hC0DE_0001, 8'h31, "R3 put");
        send(3'd4, 32'h3000_001C, 4'hF, 32'd0, 8'h32, "R3 get");
        send(3'd4, 32'h2FFF_FFFC, 4'hF, 32'd0, 8'h33, "R3 below");
        drain();

        // R11: reset with a forward pending, storage survives
        send(3'd4, 32'h0000_0500, 4'hF, 32'd0, 8'h40, "R11 dropped");
        do_reset();
        send(3'd4, 32'h3000_001C, 4'hF, 32'd0, 8'h41, "R11 retained");
        drain();

        // R6, R7: storage-less instances
        esend(3'd0, 32'h2000_0004, 8'h50, 3'd0, 1'b0, "R5 put nostore");
        esend(3'd4, 32'h2000_0004, 8'h51, 3'd1, 1'b1, "R6 get");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule